// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This peripheral holds a 16-bit counter and a 16-bit register pair that acts either as a reload value or as a capture target. Software programs it through a small byte-wide register bus. A mode decoder picks one of five behaviours:

- free-running count with capture on an external trigger,
- automatic reload while counting upward,
- automatic reload counting up or down, with the direction taken from the trigger pin,
- tick generation for a serial transmitter and receiver,
- a square-wave output with 50% duty.

The counter can step on a divided oscillator clock, on a faster divided clock in the generator modes, or on edges of an external count pin. Both external pins pass through a synchronizer before any edge is detected. The count pin and the trigger pin are synchronized on `clk`. A single level-sensitive interrupt request combines the two sticky flags.

Register addresses on `bus_sel`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | mode |
| 2 | count low byte |
| 3 | count high byte |
| 4 | reload/capture low byte |
| 5 | reload/capture high byte |

Any other address reads zero. Control bits:

| Bit | Field |
|---|---|
| 0 | external count source |
| 1 | run |
| 2 | trigger enable |
| 3 | capture select |
| 4 | transmit-tick select |
| 5 | receive-tick select |
| 6 | trigger flag |
| 7 | overflow flag |

Mode bits: bit 1 is clock-out enable and bit 0 is up/down enable.

The mode is chosen in this priority order:

1. Either tick select set gives tick generation.
2. Otherwise, clock-out enable set with the external source clear gives square-wave output.
3. Otherwise, capture select gives capture.
4. Otherwise, up/down enable gives up/down reload.
5. Otherwise the counter does upward reload.

Top module: `mmt_timer16`

## Requirements
- R1: After reset every register reads 0, and `irq`, both tick outputs, `clk_out` and `clk_out_en` are 0.
- R2: The mode register (address 1) stores bits 1:0 from a write, and its bits 7:2 always read 0.
- R3: With control bit 0 clear, the counter steps once every 12 clocks in which `osc_en` is high. With bit 0 set, it steps once per falling edge of the synchronized `cnt_pin`. With run (bit 1) clear, it does not step.
- R4: In capture mode the counter steps from FFFFh to 0000h and sets the overflow flag (bit 7). The reload/capture registers are left unchanged by this wrap.
- R5: In capture mode with trigger enable (bit 2) set, a falling edge on the synchronized `trig_pin` copies the count into registers 4/5 and sets the trigger flag (bit 6). With trigger enable clear, the edge changes neither the registers nor the flag.
- R6: In upward reload mode a step at FFFFh loads the reload value and sets the overflow flag. With the osc-divided source, overflows therefore repeat every 12×(65536−reload) clocks.
- R7: In upward reload mode with trigger enable set, a falling trigger edge loads the reload value into the counter and sets the trigger flag.
- R8: In up/down mode the synchronized trigger level selects the direction (1 = up, 0 = down). Counting up at FFFFh loads the reload value. Counting down at a count equal to the reload value loads FFFFh. Each of these sets the overflow flag and inverts the trigger flag.
- R9: `irq` is the OR of the overflow flag and the trigger flag, except that the trigger flag is excluded in up/down mode. Both flags stay set until software writes 0 to them.
- R10: With transmit-tick or receive-tick select set, the counter steps every 2 enabled clocks and reloads on overflow without setting the overflow flag. Each overflow gives a one-cycle pulse on `baud_tx_tick` and/or `baud_rx_tick`, as selected, so pulses repeat every 2×(65536−reload) clocks.
- R11: In square-wave mode the counter steps every 2 enabled clocks and reloads on overflow. `clk_out` toggles on each overflow, giving a half period of 2×(65536−reload) clocks, and the overflow flag is not set. `clk_out_en` equals clock-out enable AND NOT external source.
- R12: A software write to a count byte replaces that byte of the counter, and software writes to the flag bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator clock enable for the prescalers |
| bus_sel | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External trigger and direction input, asynchronous |
| irq | output | 1 | Interrupt request |
| baud_tx_tick | output | 1 | One-cycle transmit rate pulse |
| baud_rx_tick | output | 1 | One-cycle receive rate pulse |
| clk_out | output | 1 | Square-wave output |
| clk_out_en | output | 1 | Output enable for the square-wave pin |

## Verification
Several stimulus patterns exercise the counting function, and each one separates a different fault.

- Single pulses on the count pin around FFFFh and around the reload value show whether the boundary compare and the reload source are right in each direction. A pulse with run clear shows that the run gate works.
- Steady free-running operation on the oscillator prescaler, and on the fast divider in the two generator modes, gives overflow spacings. These spacings separate a wrong divide ratio from an off-by-one reload.
- Trigger edges with trigger enable set, then clear, distinguish capture from reload and show that the enable actually gates the edge.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   localparam int BUS_AW = 3;

   localparam logic [BUS_AW-1:0] ADDR_CTRL = 3'd0;
   localparam logic [BUS_AW-1:0] ADDR_MODE = 3'd1;
   localparam logic [BUS_AW-1:0] ADDR_CNTL = 3'd2;
   localparam logic [BUS_AW-1:0] ADDR_CNTH = 3'd3;
   localparam logic [BUS_AW-1:0] ADDR_RLDL = 3'd4;
   localparam logic [BUS_AW-1:0] ADDR_RLDH = 3'd5;

   // control byte, msb first: bit7 .. bit0
   typedef struct packed {
      logic flag_ovf;
      logic flag_ext;
      logic rx_sel;
      logic tx_sel;
      logic cap_sel;
      logic ext_en;
      logic run;
      logic src_ext;
   } ctrl_t;

   typedef enum logic [2:0] {
      MD_CAPTURE = 3'd0,
      MD_RLD_UP  = 3'd1,
      MD_RLD_UD  = 3'd2,
      MD_BAUD    = 3'd3,
      MD_CLKOUT  = 3'd4
   } mode_e;

endpackage

// File: rtl/mmt_pin_sync.sv
module mmt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mmt_pin_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= pin_i;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else prev_q <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign fall_o  = prev_q & ~chain[STAGES-1];
endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad
         $error("mmt_prescale divide ratio must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = osc_en;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else if (osc_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign tick_o = osc_en && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
   import mmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_e             mode_i,
   input  logic              step_i,
   input  logic              dir_up_i,
   input  logic              trig_reload_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  rld_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              wrap_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic at_top, at_floor, wrap;

   assign at_top   = (cnt_q == {CNT_W{1'b1}});
   assign at_floor = (cnt_q == rld_i);

   always_comb begin
      cnt_d = cnt_q;
      wrap  = 1'b0;
      if (trig_reload_i) begin
         cnt_d = rld_i;
      end else if (step_i) begin
         unique case (mode_i)
            MD_CAPTURE: begin
               cnt_d = cnt_q + 1'b1;
               wrap  = at_top;
            end
            MD_RLD_UD: begin
               if (dir_up_i) begin
                  wrap  = at_top;
                  cnt_d = at_top ? rld_i : cnt_q + 1'b1;
               end else begin
                  wrap  = at_floor;
                  cnt_d = at_floor ? {CNT_W{1'b1}} : cnt_q - 1'b1;
               end
            end
            default: begin
               wrap  = at_top;
               cnt_d = at_top ? rld_i : cnt_q + 1'b1;
            end
         endcase
      end
      if (wr_lo_i) cnt_d[DATA_W-1:0] = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:DATA_W] = wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;
   assign wrap_o  = wrap;
endmodule

// File: rtl/mmt_regs.sv
module mmt_regs
   import mmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              cap_load_i,
   input  logic              ovf_set_i,
   input  logic              ext_set_i,
   input  logic              ext_toggle_i,
   output ctrl_t             ctrl_o,
   output logic              out_en_o,
   output logic              down_en_o,
   output logic [CNT_W-1:0]  rld_o
);
   ctrl_t            ctrl_q;
   logic [1:0]       mode_q;
   logic [CNT_W-1:0] rld_q;
   logic wr_ctrl, wr_mode, wr_rl, wr_rh;

   assign wr_ctrl = bus_wr && (bus_sel == ADDR_CTRL);
   assign wr_mode = bus_wr && (bus_sel == ADDR_MODE);
   assign wr_rl   = bus_wr && (bus_sel == ADDR_RLDL);
   assign wr_rh   = bus_wr && (bus_sel == ADDR_RLDH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
         // hardware events win over a same-cycle software write
         if (ovf_set_i) ctrl_q.flag_ovf <= 1'b1;
         if (ext_set_i) ctrl_q.flag_ext <= 1'b1;
         else if (ext_toggle_i) ctrl_q.flag_ext <= ~ctrl_q.flag_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (wr_mode) mode_q <= bus_wdata[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= '0;
      end else if (cap_load_i) begin
         rld_q <= count_i;
      end else begin
         if (wr_rl) rld_q[DATA_W-1:0] <= bus_wdata;
         if (wr_rh) rld_q[CNT_W-1:DATA_W] <= bus_wdata;
      end
   end

   always_comb begin
      unique case (bus_sel)
         ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
         ADDR_MODE: bus_rdata = {{(DATA_W-2){1'b0}}, mode_q};
         ADDR_CNTL: bus_rdata = count_i[DATA_W-1:0];
         ADDR_CNTH: bus_rdata = count_i[CNT_W-1:DATA_W];
         ADDR_RLDL: bus_rdata = rld_q[DATA_W-1:0];
         ADDR_RLDH: bus_rdata = rld_q[CNT_W-1:DATA_W];
         default:   bus_rdata = '0;
      endcase
   end

   assign ctrl_o    = ctrl_q;
   assign out_en_o  = mode_q[1];
   assign down_en_o = mode_q[0];
   assign rld_o     = rld_q;
endmodule

// File: rtl/mmt_timer16.sv
module mmt_timer16
   import mmt_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 8,
   parameter int SLOW_DIV  = 12,
   parameter int FAST_DIV  = 2,
   parameter int SYNC_STG  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic [2:0]        bus_sel,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              cnt_pin,
   input  logic              trig_pin,
   output logic              irq,
   output logic              baud_tx_tick,
   output logic              baud_rx_tick,
   output logic              clk_out,
   output logic              clk_out_en
);
   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("bus is byte wide");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cw
         $error("counter must be two bus bytes wide");
      end
   endgenerate

   ctrl_t            ctl;
   logic             ctl_out_en, ctl_down_en;
   logic             ctl_run, ctl_exten, ctl_tx, ctl_rx;
   logic [CNT_W-1:0] rld, cnt_q;
   logic             flag_ovf, gen_mode;
   mode_e            mode;
   logic             slow_tick, fast_tick;
   logic             cnt_lvl, cnt_fall, trig_lvl, trig_fall;
   logic             src_tick, step, wrap;
   logic             cap_load, trig_reload, ovf_set, ext_set, ext_toggle;
   logic             tx_q, rx_q, clk_q;

   mmt_pin_sync #(.STAGES(SYNC_STG)) u_sync_cnt (
      .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin),
      .level_o(cnt_lvl), .fall_o(cnt_fall));

   mmt_pin_sync #(.STAGES(SYNC_STG)) u_sync_trig (
      .clk(clk), .rst_n(rst_n), .pin_i(trig_pin),
      .level_o(trig_lvl), .fall_o(trig_fall));

   mmt_prescale #(.DIV(SLOW_DIV)) u_pre_slow (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick_o(slow_tick));

   mmt_prescale #(.DIV(FAST_DIV)) u_pre_fast (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick_o(fast_tick));

   assign ctl_run   = ctl.run;
   assign ctl_exten = ctl.ext_en;
   assign ctl_tx    = ctl.tx_sel;
   assign ctl_rx    = ctl.rx_sel;
   assign flag_ovf  = ctl.flag_ovf;

   always_comb begin
      if (ctl.tx_sel || ctl.rx_sel)        mode = MD_BAUD;
      else if (ctl_out_en && !ctl.src_ext) mode = MD_CLKOUT;
      else if (ctl.cap_sel)                mode = MD_CAPTURE;
      else if (ctl_down_en)                mode = MD_RLD_UD;
      else                                 mode = MD_RLD_UP;
   end

   assign gen_mode = (mode == MD_BAUD) || (mode == MD_CLKOUT);

   always_comb begin
      if (gen_mode)         src_tick = fast_tick;
      else if (ctl.src_ext) src_tick = cnt_fall & cnt_lvl_unused_guard();
      else                  src_tick = slow_tick;
   end

   // level of the count pin is known low right after a falling edge
   function automatic logic cnt_lvl_unused_guard();
      return ~cnt_lvl;
   endfunction

   assign step        = ctl.run && src_tick;
   assign cap_load    = trig_fall && ctl.ext_en && (mode == MD_CAPTURE);
   assign trig_reload = trig_fall && ctl.ext_en && (mode == MD_RLD_UP);
   assign ext_set     = trig_fall && ctl.ext_en &&
                        (mode == MD_CAPTURE || mode == MD_RLD_UP || mode == MD_BAUD);
   assign ext_toggle  = wrap && (mode == MD_RLD_UD);
   assign ovf_set     = wrap && !gen_mode;

   mmt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .step_i(step),
      .dir_up_i(trig_lvl), .trig_reload_i(trig_reload),
      .wr_lo_i(bus_wr && (bus_sel == ADDR_CNTL)),
      .wr_hi_i(bus_wr && (bus_sel == ADDR_CNTH)),
      .wdata_i(bus_wdata), .rld_i(rld), .count_o(cnt_q), .wrap_o(wrap));

   mmt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_i(cnt_q),
      .cap_load_i(cap_load), .ovf_set_i(ovf_set), .ext_set_i(ext_set),
      .ext_toggle_i(ext_toggle), .ctrl_o(ctl), .out_en_o(ctl_out_en),
      .down_en_o(ctl_down_en), .rld_o(rld));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         rx_q  <= 1'b0;
         clk_q <= 1'b0;
      end else begin
         tx_q <= wrap && (mode == MD_BAUD) && ctl.tx_sel;
         rx_q <= wrap && (mode == MD_BAUD) && ctl.rx_sel;
         if (wrap && (mode == MD_CLKOUT)) clk_q <= ~clk_q;
      end
   end

   assign baud_tx_tick = tx_q;
   assign baud_rx_tick = rx_q;
   assign clk_out      = clk_q;
   assign clk_out_en   = ctl_out_en && !ctl.src_ext;
   assign irq          = ctl.flag_ovf || (ctl.flag_ext && (mode != MD_RLD_UD));
endmodule

// File: rtl/mmt_chk.sv
module mmt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic [2:0]  bus_sel,
   input logic [7:0]  bus_rdata,
   input logic        baud_tx_tick,
   input logic        baud_rx_tick,
   input logic        clk_out,
   input logic        clk_out_en,
   input logic        tx_sel,
   input logic        rx_sel,
   input logic        run,
   input logic        ext_en,
   input logic        gen_mode,
   input logic        ovf_flag,
   input logic [15:0] count
);
   assert_mode_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == 3'd1) |-> (bus_rdata[7:2] == 6'd0));

   assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !bus_wr && !ext_en) |=> $stable(count));

   assert_tx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_sel |=> !baud_tx_tick);

   assert_rx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_sel |=> !baud_rx_tick);

   assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tx_tick |=> !baud_tx_tick);

   assert_no_ovf_gen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_mode && !(bus_wr && bus_sel == 3'd0)) |=> !$rose(ovf_flag));

   assert_clkout_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_out_en |=> $stable(clk_out));
endmodule

bind mmt_timer16 mmt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
   .bus_rdata(bus_rdata), .baud_tx_tick(baud_tx_tick),
   .baud_rx_tick(baud_rx_tick), .clk_out(clk_out), .clk_out_en(clk_out_en),
   .tx_sel(ctl_tx), .rx_sel(ctl_rx), .run(ctl_run), .ext_en(ctl_exten),
   .gen_mode(gen_mode), .ovf_flag(flag_ovf), .count(cnt_q));

// File: tb/mmt_timer16_test.sv
`timescale 1ns/100ps
module mmt_timer16_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b1;
   logic [2:0] bus_sel = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cnt_pin = 1'b0;
   logic       trig_pin = 1'b0;
   logic       irq, baud_tx_tick, baud_rx_tick, clk_out, clk_out_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   mmt_timer16 uut (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq),
      .baud_tx_tick(baud_tx_tick), .baud_rx_tick(baud_rx_tick),
      .clk_out(clk_out), .clk_out_en(clk_out_en));

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd16(input logic [2:0] a, output logic [15:0] d);
      logic [7:0] lo, hi;
      rd(a, lo);
      rd(a + 3'd1, hi);
      d = {hi, lo};
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] d);
      wr(a, d[7:0]);
      wr(a + 3'd1, d[15:8]);
   endtask

   task automatic pulse_cnt();
      @(negedge clk); cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
      cnt_pin = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_pin = 1'b1;
      repeat (4) @(negedge clk);
      trig_pin = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   // waits at negedges until sig is 1; returns cycle stamp, -1 on timeout
   task automatic wait_high(input int which, input int limit, output int stamp);
      stamp = -1;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if ((which == 0 && irq) || (which == 1 && baud_tx_tick) ||
             (which == 2 && baud_rx_tick)) begin
            stamp = cyc;
            break;
         end
      end
   endtask

   task automatic clear_all();
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      trig_pin = 1'b0;
      cnt_pin = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 register reset", d, 0);
      end
      check("R1 outputs reset", {irq, baud_tx_tick, baud_rx_tick, clk_out, clk_out_en}, 0);
   endtask

   task automatic t_mode_reg();
      logic [7:0] d;
      wr(3'd1, 8'hFF);
      rd(3'd1, d);
      check("R2 mode upper bits zero", d, 8'h03);
      wr(3'd1, 8'hFE);
      rd(3'd1, d);
      check("R2 mode bits stored", d, 8'h02);
      clear_all();
   endtask

   task automatic t_sw_write();
      logic [15:0] v;
      logic [7:0] d;
      wr16(3'd2, 16'hA55A);
      rd16(3'd2, v);
      check("R12 count write", v, 16'hA55A);
      wr(3'd0, 8'hC0);
      rd(3'd0, d);
      check("R12 flags writable", d, 8'hC0);
      check("R9 irq from flags", irq, 1);
      wr(3'd0, 8'h00);
      check("R9 irq cleared by write", irq, 0);
   endtask

   task automatic t_run_gate_and_prescale();
      logic [15:0] v, v2;
      int t1, t2;
      clear_all();
      wr16(3'd2, 16'h0100);
      wr(3'd0, 8'h09);            // external source, capture, run clear
      pulse_cnt();
      rd16(3'd2, v);
      check("R3 run clear holds count", v, 16'h0100);
      wr(3'd0, 8'h0A);            // osc source, capture, run
      rd16(3'd2, v);
      t1 = -1; t2 = -1;
      for (int i = 0; i < 100; i++) begin
         rd16(3'd2, v2);
         if (v2 != v) begin
            if (t1 < 0) t1 = cyc; else begin t2 = cyc; break; end
            v = v2;
         end
      end
      // rd16 spans two cycles; step spacing of 12 is a multiple of 2
      check("R3 prescale spacing 12", t2 - t1, 12);
      clear_all();
   endtask

   task automatic t_capture_wrap();
      logic [15:0] v;
      logic [7:0] d;
      clear_all();
      wr16(3'd4, 16'h1234);
      wr16(3'd2, 16'hFFFE);
      wr(3'd0, 8'h0B);            // external source, run, capture
      pulse_cnt();
      rd16(3'd2, v);
      check("R3 external edge steps", v, 16'hFFFF);
      rd(3'd0, d);
      check("R4 no flag before wrap", d[7], 0);
      pulse_cnt();
      rd16(3'd2, v);
      check("R4 wrap to zero", v, 16'h0000);
      rd(3'd0, d);
      check("R4 overflow flag", d[7], 1);
      rd16(3'd4, v);
      check("R4 capture regs untouched", v, 16'h1234);
      clear_all();
   endtask

   task automatic t_capture_trig();
      logic [15:0] v;
      logic [7:0] d;
      clear_all();
      wr16(3'd2, 16'h1234);
      wr(3'd0, 8'h0C);            // capture, trigger enable, stopped
      pulse_trig();
      rd16(3'd4, v);
      check("R5 capture copies count", v, 16'h1234);
      rd(3'd0, d);
      check("R5 trigger flag set", d[6], 1);
      check("R9 irq from trigger flag", irq, 1);
      wr(3'd0, 8'h08);            // trigger enable off, flags clear
      wr16(3'd2, 16'h5678);
      pulse_trig();
      rd16(3'd4, v);
      check("R5 disabled trigger ignored", v, 16'h1234);
      rd(3'd0, d);
      check("R5 disabled trigger no flag", d[6], 0);
      clear_all();
   endtask

   task automatic t_reload_up();
      logic [15:0] v;
      int t1, t2;
      clear_all();
      wr16(3'd4, 16'hFFF8);
      wr16(3'd2, 16'hFFF8);
      wr(3'd0, 8'h02);
      wait_high(0, 400, t1);
      bus_sel = 3'd2; #1 v[7:0] = bus_rdata;
      bus_sel = 3'd3; #1 v[15:8] = bus_rdata;
      check("R6 reload on overflow", v, 16'hFFF8);
      wr(3'd0, 8'h02);
      wait_high(0, 400, t2);
      check("R6 overflow period", t2 - t1, 96);
      clear_all();
      wr16(3'd4, 16'hABCD);
      wr16(3'd2, 16'h0100);
      wr(3'd0, 8'h04);            // reload up, trigger enable, stopped
      pulse_trig();
      rd16(3'd2, v);
      check("R7 trigger reload", v, 16'hABCD);
      check("R7 trigger flag", irq, 1);
      clear_all();
   endtask

   task automatic t_updown();
      logic [15:0] v;
      logic [7:0] d;
      clear_all();
      wr(3'd1, 8'h01);
      wr16(3'd4, 16'h0010);
      wr16(3'd2, 16'h0012);
      wr(3'd0, 8'h03);            // external source, run
      pulse_cnt();
      pulse_cnt();
      rd16(3'd2, v);
      check("R8 down count", v, 16'h0010);
      pulse_cnt();
      rd16(3'd2, v);
      check("R8 underflow loads FFFF", v, 16'hFFFF);
      rd(3'd0, d);
      check("R8 flags after underflow", d[7:6], 2'b11);
      wr(3'd0, 8'h43);            // clear overflow, keep trigger flag
      check("R9 trigger flag masked in up/down", irq, 0);
      trig_pin = 1'b1;
      repeat (5) @(negedge clk);
      pulse_cnt();
      rd16(3'd2, v);
      check("R8 up overflow reloads", v, 16'h0010);
      rd(3'd0, d);
      check("R8 trigger flag toggled back", d[7:6], 2'b10);
      clear_all();
   endtask

   task automatic t_baud();
      logic [7:0] d;
      int t1, t2, nrx;
      clear_all();
      wr16(3'd4, 16'hFFFC);
      wr16(3'd2, 16'hFFFC);
      wr(3'd0, 8'h12);            // transmit select, run
      wait_high(1, 100, t1);
      nrx = 0;
      t2 = -1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (baud_rx_tick) nrx++;
         if (baud_tx_tick && t2 < 0) t2 = cyc;
      end
      check("R10 transmit tick period", t2 - t1, 8);
      check("R10 receive tick unselected", nrx, 0);
      rd(3'd0, d);
      check("R10 no overflow flag", d[7], 0);
      wr(3'd0, 8'h22);            // receive select, run
      wait_high(2, 100, t1);
      wait_high(2, 100, t2);
      check("R10 receive tick period", t2 - t1, 8);
      clear_all();
   endtask

   task automatic t_clkout();
      logic [7:0] d;
      int t1, t2;
      logic last;
      clear_all();
      wr16(3'd4, 16'hFFF0);
      wr16(3'd2, 16'hFFF0);
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h02);
      check("R11 output enable", clk_out_en, 1);
      t1 = -1; t2 = -1;
      @(negedge clk); last = clk_out;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (clk_out != last) begin
            last = clk_out;
            if (t1 < 0) t1 = cyc; else begin t2 = cyc; break; end
         end
      end
      check("R11 half period", t2 - t1, 32);
      rd(3'd0, d);
      check("R11 no overflow flag", d[7], 0);
      wr(3'd0, 8'h01);
      check("R11 enable off with external source", clk_out_en, 0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mode_reg();
      t_sw_write();
      t_run_gate_and_prescale();
      t_capture_wrap();
      t_capture_trig();
      t_reload_up();
      t_updown();
      t_baud();
      t_clkout();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule